// File: doc/BRIEF.md
# Sampler Speed Stabilization Controller

This block holds the revolution rate of a free-running sampling wave steady while temperature and supply voltage drift. It measures the rate by counting one-cycle turn pulses from the sampler inside a gate. The gate spans a programmable number of reference-clock periods, and the reference is supplied as a one-cycle tick. When a gate closes, the block subtracts the count from a programmed target. It looks up a signed correction step for that error in a 16-entry table and adds the step to a 16-bit speed-control DAC code. The code saturates at both ends of its range.

The DAC code is only allowed to move between events. While the acquisition-busy flag is high, the code is frozen and any new correction is held pending. The pending correction is written in the first cycle that acquisition is idle, and a newer correction replaces an older one that has not been written yet. A lock flag reports that the loop has settled: a programmable number of consecutive gates had an error inside a deadband.

All inputs are synchronous to `clk`. A higher DAC code is taken to make the wave run faster, so a count below target raises the code.

Top module: `wave_speed_ctrl`

## Requirements
- R1: While `rst_n` is low and directly after its release, `dac_code` equals the INIT_CODE parameter (default 32768), `dac_wr` is 0 and `locked` is 0.
- R2: A gate closes on the cycle with the `cfg_gate_len`-th `ref_tick` since the previous gate closed (0 is treated as 1). Its count covers every `turn_pulse` cycle after the previous closing cycle, up to and including the closing cycle. The first gate starts at reset release.
- R3: The error is `cfg_target` minus the count, and is clamped to the range -8..+7. The table index is the clamped error plus 8, giving entries 0..15. The step is e*|e|*GAIN, where e is the clamped error and GAIN defaults to 4. So +7 gives +196 and -8 gives -256.
- R4: For each correction that is applied, `dac_code` becomes the old code plus the step, and `dac_wr` is high for exactly that one cycle. With `acq_busy` low, this happens 4 clock edges after the edge that samples the closing `ref_tick`.
- R5: `dac_wr` is never high in a cycle that follows a cycle with `acq_busy` high, so the code stays constant through an acquisition.
- R6: A correction that becomes ready while `acq_busy` is high is kept pending and written on the edge after the first idle cycle. If a newer correction arrives first, it replaces the pending one, and only the latest is written.
- R7: `locked` rises after `cfg_lock_gates` consecutive gates (0 is treated as 1) whose unclamped |error| is at most `cfg_deadband`. A single gate outside the deadband clears it. It changes 3 edges after the closing edge.
- R8: `dac_code` changes only in a cycle in which `dac_wr` is high.
- R9: The code saturates at 0 and at 65535 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| turn_pulse | input | 1 | One-cycle pulse per wave revolution |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| acq_busy | input | 1 | High while an acquisition is in progress |
| cfg_target | input | CNT_W | Target turn count per gate |
| cfg_gate_len | input | GATE_W | Reference periods per gate |
| cfg_deadband | input | DB_W | Largest |error| counted as in band |
| cfg_lock_gates | input | LOCK_W | In-band gates in a row needed for lock |
| dac_code | output | 16 | Speed-control DAC code |
| dac_wr | output | 1 | Write strobe, high in the cycle a new code appears |
| locked | output | 1 | Loop settled |

## Verification
A gate-closing edge produces a registered count after 1 edge and a table step after 2. The lock flag is due after 3 edges and the DAC write after 4, or later if a busy acquisition holds the write back. The bench runs 16-cycle gates, so every result of gate j lands within the first four cycles of gate j+1. The scoreboard therefore predicts writes at the start of gate j+1 and checks them whenever a strobe appears. Lock state and the current code are compared on the last cycle of each gate, long after both have settled. Busy gates are checked as a whole: no strobe may appear in them, and the pending replacement must produce exactly the predicted writes once the flag drops.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int CODE_W    = 16;
  localparam int STEP_W    = 18;
  localparam int LUT_DEPTH = 16;
  localparam int LUT_IDX_W = $clog2(LUT_DEPTH);
  localparam int LUT_BIAS  = LUT_DEPTH / 2;

  // Step for table entry idx: e = idx - bias, step = e*|e|*gain
  function automatic logic signed [STEP_W-1:0] lut_step(input int idx, input int gain);
    int e;
    int mag;
    e   = idx - LUT_BIAS;
    mag = (e < 0) ? -e : e;
    return STEP_W'(e * mag * gain);
  endfunction
endpackage

// File: rtl/wsc_freq_meter.sv
module wsc_freq_meter #(
  parameter int CNT_W  = 16,
  parameter int GATE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             turn_pulse,
  input  logic [GATE_W-1:0] gate_len,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [GATE_W-1:0] ref_cnt_q, ref_cnt_n;
  logic [CNT_W-1:0]  turn_cnt_q, turn_cnt_n, turn_inc;
  logic [CNT_W-1:0]  meas_count_n;
  logic              meas_valid_n;
  logic [GATE_W-1:0] len_eff;
  logic              gate_end;

  always_comb begin
    len_eff  = (gate_len == '0) ? GATE_W'(1) : gate_len;
    gate_end = ref_tick && ((ref_cnt_q + GATE_W'(1)) >= len_eff);
    turn_inc = (turn_pulse && (turn_cnt_q != CNT_MAX)) ? turn_cnt_q + CNT_W'(1) : turn_cnt_q;

    ref_cnt_n    = ref_cnt_q;
    turn_cnt_n   = turn_inc;
    meas_count_n = meas_count;
    meas_valid_n = 1'b0;
    if (gate_end) begin
      ref_cnt_n    = '0;
      turn_cnt_n   = '0;
      meas_count_n = turn_inc;
      meas_valid_n = 1'b1;
    end else if (ref_tick) begin
      ref_cnt_n = ref_cnt_q + GATE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_q  <= '0;
      turn_cnt_q <= '0;
      meas_count <= '0;
      meas_valid <= 1'b0;
    end else begin
      ref_cnt_q  <= ref_cnt_n;
      turn_cnt_q <= turn_cnt_n;
      meas_count <= meas_count_n;
      meas_valid <= meas_valid_n;
    end
  end
endmodule

// File: rtl/wsc_step_lut.sv
module wsc_step_lut
  import wsc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 8,
  parameter int GAIN  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     meas_valid,
  input  logic [CNT_W-1:0]         meas_count,
  input  logic [CNT_W-1:0]         target,
  input  logic [DB_W-1:0]          deadband,
  output logic                     corr_valid,
  output logic signed [STEP_W-1:0] corr_step,
  output logic                     corr_inband
);
  localparam int ERR_W = CNT_W + 1;

  logic signed [STEP_W-1:0] table_q [LUT_DEPTH];

  for (genvar gi = 0; gi < LUT_DEPTH; gi++) begin : g_tbl
    assign table_q[gi] = lut_step(gi, GAIN);
  end

  logic signed [ERR_W-1:0] err;
  logic        [ERR_W-1:0] err_mag;
  logic [LUT_IDX_W-1:0]    idx;
  logic                    inband_n;
  logic signed [STEP_W-1:0] step_n;

  always_comb begin
    err     = $signed({1'b0, target}) - $signed({1'b0, meas_count});
    err_mag = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
    if (err > $signed(ERR_W'(LUT_BIAS - 1)))
      idx = LUT_IDX_W'(LUT_DEPTH - 1);
    else if (err < -$signed(ERR_W'(LUT_BIAS)))
      idx = '0;
    else
      idx = err[LUT_IDX_W-1:0] ^ LUT_IDX_W'(LUT_BIAS);
    step_n   = table_q[idx];
    inband_n = err_mag <= ERR_W'(deadband);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_valid  <= 1'b0;
      corr_step   <= '0;
      corr_inband <= 1'b0;
    end else begin
      corr_valid <= meas_valid;
      if (meas_valid) begin
        corr_step   <= step_n;
        corr_inband <= inband_n;
      end
    end
  end
endmodule

// File: rtl/wsc_dac_gate.sv
module wsc_dac_gate
  import wsc_pkg::*;
#(
  parameter logic [CODE_W-1:0] INIT_CODE = 16'd32768
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     corr_valid,
  input  logic signed [STEP_W-1:0] corr_step,
  input  logic                     acq_busy,
  output logic [CODE_W-1:0]        dac_code,
  output logic                     dac_wr,
  output logic                     pend
);
  localparam int SUM_W = CODE_W + 3;

  logic signed [STEP_W-1:0] pend_step_q, pend_step_n;
  logic                     pend_n;
  logic [CODE_W-1:0]        code_n;
  logic                     wr_n;
  logic signed [SUM_W-1:0]  sum;
  logic                     apply;

  always_comb begin
    apply = pend && !acq_busy;
    sum   = $signed({3'b000, dac_code}) + SUM_W'(pend_step_q);
    code_n = dac_code;
    wr_n   = 1'b0;
    if (apply) begin
      wr_n = 1'b1;
      if (sum < 0)
        code_n = '0;
      else if (sum > $signed({3'b000, {CODE_W{1'b1}}}))
        code_n = {CODE_W{1'b1}};
      else
        code_n = sum[CODE_W-1:0];
    end
    pend_n      = pend && !apply;
    pend_step_n = pend_step_q;
    if (corr_valid) begin
      pend_n      = 1'b1;
      pend_step_n = corr_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code    <= INIT_CODE;
      dac_wr      <= 1'b0;
      pend        <= 1'b0;
      pend_step_q <= '0;
    end else begin
      dac_code    <= code_n;
      dac_wr      <= wr_n;
      pend        <= pend_n;
      pend_step_q <= pend_step_n;
    end
  end
endmodule

// File: rtl/wsc_lock_det.sv
module wsc_lock_det #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              corr_valid,
  input  logic              corr_inband,
  input  logic [LOCK_W-1:0] lock_gates,
  output logic              locked
);
  logic [LOCK_W-1:0] run_q, run_n, need;
  logic              locked_n;

  always_comb begin
    need     = (lock_gates == '0) ? LOCK_W'(1) : lock_gates;
    run_n    = run_q;
    locked_n = locked;
    if (corr_valid) begin
      if (corr_inband) begin
        if (run_q < need) run_n = run_q + LOCK_W'(1);
        locked_n = (run_n >= need);
      end else begin
        run_n    = '0;
        locked_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      locked <= 1'b0;
    end else begin
      run_q  <= run_n;
      locked <= locked_n;
    end
  end
endmodule

// File: rtl/wave_speed_ctrl.sv
module wave_speed_ctrl
  import wsc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GATE_W = 16,
  parameter int DB_W   = 8,
  parameter int LOCK_W = 8,
  parameter int GAIN   = 4,
  parameter logic [CODE_W-1:0] INIT_CODE = 16'd32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              turn_pulse,
  input  logic              ref_tick,
  input  logic              acq_busy,
  input  logic [CNT_W-1:0]  cfg_target,
  input  logic [GATE_W-1:0] cfg_gate_len,
  input  logic [DB_W-1:0]   cfg_deadband,
  input  logic [LOCK_W-1:0] cfg_lock_gates,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_wr,
  output logic              locked
);
  logic                     meas_valid;
  logic [CNT_W-1:0]         meas_count;
  logic                     corr_valid;
  logic signed [STEP_W-1:0] corr_step;
  logic                     corr_inband;
  logic                     pend;

  wsc_freq_meter #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .turn_pulse(turn_pulse),
    .gate_len(cfg_gate_len), .meas_valid(meas_valid), .meas_count(meas_count)
  );

  wsc_step_lut #(.CNT_W(CNT_W), .DB_W(DB_W), .GAIN(GAIN)) u_lut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_count(meas_count),
    .target(cfg_target), .deadband(cfg_deadband),
    .corr_valid(corr_valid), .corr_step(corr_step), .corr_inband(corr_inband)
  );

  wsc_dac_gate #(.INIT_CODE(INIT_CODE)) u_dac (
    .clk(clk), .rst_n(rst_n), .corr_valid(corr_valid), .corr_step(corr_step),
    .acq_busy(acq_busy), .dac_code(dac_code), .dac_wr(dac_wr), .pend(pend)
  );

  wsc_lock_det #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .corr_valid(corr_valid), .corr_inband(corr_inband),
    .lock_gates(cfg_lock_gates), .locked(locked)
  );
endmodule

// File: rtl/wave_speed_ctrl_chk.sv
module wave_speed_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acq_busy,
  input logic [15:0] dac_code,
  input logic        dac_wr,
  input logic        locked,
  input logic        meas_valid,
  input logic        corr_valid,
  input logic        pend
);
  assert_wr_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr |-> !$past(acq_busy));

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr |-> $stable(dac_code));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr |=> !dac_wr);

  assert_pend_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |=> pend);

  assert_meas_to_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> corr_valid);

  assert_lock_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(corr_valid));
endmodule

bind wave_speed_ctrl wave_speed_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acq_busy(acq_busy), .dac_code(dac_code),
  .dac_wr(dac_wr), .locked(locked), .meas_valid(meas_valid),
  .corr_valid(corr_valid), .pend(pend)
);

// File: tb/wave_speed_ctrl_bench.sv
module wave_speed_ctrl_bench;
  localparam int GATE_CYC = 16;
  localparam int TARGET0  = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        turn_pulse, ref_tick, acq_busy;
  logic [15:0] cfg_target, cfg_gate_len;
  logic [7:0]  cfg_deadband, cfg_lock_gates;
  logic [15:0] dac_code;
  logic        dac_wr, locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  wave_speed_ctrl u_wave_speed_ctrl (
    .clk(clk), .rst_n(rst_n), .turn_pulse(turn_pulse), .ref_tick(ref_tick),
    .acq_busy(acq_busy), .cfg_target(cfg_target), .cfg_gate_len(cfg_gate_len),
    .cfg_deadband(cfg_deadband), .cfg_lock_gates(cfg_lock_gates),
    .dac_code(dac_code), .dac_wr(dac_wr), .locked(locked)
  );

  // reference model state
  int exp_code = 32768;
  int code_q[$];
  bit prev_v = 0; int prev_step; bit prev_in;
  bit pend_v = 0; int pend_step;
  int lk_run = 0; bit lk_exp = 0;
  int target_m = TARGET0;

  function automatic int step_of(int n);
    int e;
    e = target_m - n;
    if (e > 7) e = 7;
    if (e < -8) e = -8;
    return e * ((e < 0) ? -e : e) * 4;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_write(int step);
    exp_code = exp_code + step;
    if (exp_code < 0) exp_code = 0;
    if (exp_code > 65535) exp_code = 65535;
    code_q.push_back(exp_code);
  endtask

  // apply the previous gate's result to the model, as seen during a gate with this busy value
  task automatic model_step(bit busy);
    if (prev_v) begin
      if (prev_in) begin
        if (lk_run < 3) lk_run++;
        lk_exp = (lk_run >= 3);
      end else begin
        lk_run = 0;
        lk_exp = 0;
      end
    end
    if (busy) begin
      if (prev_v) begin pend_v = 1; pend_step = prev_step; end
    end else begin
      if (pend_v) begin push_write(pend_step); pend_v = 0; end
      if (prev_v) push_write(prev_step);
    end
  endtask

  // driver: one 16-cycle gate (4 ticks x 4 cycles) with n turn pulses
  task automatic run_gate(int n, bit busy);
    model_step(busy);
    for (int c = 0; c < GATE_CYC; c++) begin
      @(negedge clk);
      if (c == GATE_CYC - 1) begin
        check(locked == lk_exp, "R7 lock", int'(locked), int'(lk_exp));
        check(int'(dac_code) == exp_code, "R4 code at gate end", int'(dac_code), exp_code);
      end
      acq_busy   = busy;
      turn_pulse = (c < n);
      ref_tick   = (c % 4 == 3);
    end
    prev_v    = 1;
    prev_step = step_of(n);
    prev_in   = ((target_m - n) <= int'(cfg_deadband)) && ((n - target_m) <= int'(cfg_deadband));
  endtask

  task automatic drain();
    model_step(1'b0);
    prev_v = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      acq_busy = 0; turn_pulse = 0; ref_tick = 0;
    end
    check(code_q.size() == 0, "R6 missing writes", code_q.size(), 0);
    check(int'(dac_code) == exp_code, "R4 final code", int'(dac_code), exp_code);
  endtask

  // monitor: pops expected codes as strobes appear
  always @(negedge clk) begin
    if (rst_n && dac_wr) begin
      if (code_q.size() == 0) begin
        check(1'b0, "R5 unexpected write", int'(dac_code), exp_code);
      end else begin
        int e;
        e = code_q.pop_front();
        check(int'(dac_code) == e, "R4 written code", int'(dac_code), e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; turn_pulse = 0; ref_tick = 0; acq_busy = 0;
    cfg_target = 16'(TARGET0); cfg_gate_len = 16'd4;
    cfg_deadband = 8'd1; cfg_lock_gates = 8'd3;
    repeat (4) @(negedge clk);
    check(dac_code == 16'd32768, "R1 reset code", int'(dac_code), 32768);
    check(dac_wr == 1'b0, "R1 reset strobe", int'(dac_wr), 0);
    check(locked == 1'b0, "R1 reset lock", int'(locked), 0);
    rst_n = 1;
    // R2/R3: several counts, including a pulse in the closing cycle (16)
    run_gate(10, 0);
    run_gate(12, 0);
    run_gate(7, 0);
    run_gate(0, 0);
    run_gate(16, 0);
    // R7: three in-band gates lock, an out-of-band gate unlocks
    run_gate(10, 0);
    run_gate(11, 0);
    run_gate(9, 0);
    run_gate(10, 0);
    run_gate(13, 0);
    run_gate(10, 0);
    // R5/R6: busy gates hold and replace the pending correction
    run_gate(6, 0);
    run_gate(14, 1);
    run_gate(5, 1);
    run_gate(12, 1);
    run_gate(9, 0);
    run_gate(3, 1);
    run_gate(10, 0);
    // R9: saturate high
    for (int i = 0; i < 175; i++) run_gate(0, 0);
    run_gate(0, 0);
    check(dac_code == 16'hFFFF, "R9 high saturation", int'(dac_code), 65535);
    // R9: saturate low
    target_m = 0; cfg_target = 16'd0;
    for (int i = 0; i < 262; i++) run_gate(16, i % 40 == 7);
    run_gate(16, 0);
    check(dac_code == 16'h0000, "R9 low saturation", int'(dac_code), 0);
    drain();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule